// File: doc/BRIEF.md
# Security-Banked Binary Point Register Slice

This block holds the binary point setting of an interrupt controller's processor interface, one setting per processor. The binary point decides where an interrupt priority is cut into a group-priority part and a subpriority part. Each processor owns two 3-bit copies: a primary copy, which is the secure copy or the only copy, and a non-secure copy. The block steers every register access to one of these copies, to neither, or to a read-as-zero result. The choice depends on the word offset, the security attribute of the access and two configuration inputs.

The register port has a processor index, a byte offset, a write strobe with write data and a secure-access flag. Reads are combinational from the addressed processor's storage. Writes land on the rising clock edge. Both copies of every processor are also driven out as flat vectors for the priority logic that consumes them. Two configuration inputs select whether security extensions are present and whether interrupt grouping is implemented. Grouping is what makes the alias window exist.

Top module: `bp_bank_regs`

## Requirements
- R1: After reset, every processor's primary copy is 0 and every processor's non-secure copy is 1.
- R2: A write uses only wdata_i[2:0]. A read returns the selected 3-bit value in rdata_o[2:0], and rdata_o[31:3] is 0.
- R3: When security extensions are on, a non-secure access at offset 0x08 reads and writes the non-secure copy.
- R4: Every other access at offset 0x08 reads and writes the primary copy. That covers a secure access, and any access when security extensions are off.
- R5: When grouping is off, offset 0x1c reads as 0 and writes to it change no copy.
- R6: When security extensions are on, a non-secure access at offset 0x1c reads as 0 and its writes change no copy.
- R7: When grouping is on and the R6 case does not apply, offset 0x1c reads and writes the non-secure copy. This gives a secure access a view of the non-secure setting.
- R8: A write to the non-secure copy is clamped to at least 1, so a written 0 is stored as 1. A write to the primary copy stores the value as given, including 0.
- R9: Any offset other than 0x08 and 0x1c reads as 0, and writes to it change no copy.
- R10: A processor index at or above NUM_CPU reads as 0, and writes with it change no copy.
- R11: A write changes only the addressed processor's selected copy. The new value appears on the next rising clock edge, and a read in the same cycle as the write still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_sec_ext_i | input | 1 | Security extensions present |
| cfg_groups_i | input | 1 | Interrupt grouping implemented (alias window exists) |
| cpu_idx_i | input | IDX_W (4) | Processor index of the access |
| offset_i | input | OFF_W (12) | Byte offset within the processor interface space |
| secure_i | input | 1 | Access carries the secure attribute |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data |
| bp_sec_o | output | NUM_CPU*3 (24) | Primary copies; processor c occupies bits [3c+2:3c] |
| bp_ns_o | output | NUM_CPU*3 (24) | Non-secure copies; same packing |

## Verification
A read result is due in the same cycle as its stimulus, because rdata_o comes from the addressed storage with no register in the path. A write result is due one rising edge later, on both the flat copy outputs and later reads. The bench drives each vector at the falling edge and compares one time unit later against a behavioural model that still holds the pre-edge state. The model commits a write only after the following rising edge, so every comparison sees exactly the values the design should present in that cycle, including the old value read back during a write.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int BP_W       = 3;
  localparam int BP_OFF     = 'h08;
  localparam int ALIAS_OFF  = 'h1c;
  localparam int PRI_MIN    = 0;
  localparam int NS_MIN     = 1;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PRI  = 2'd1,
    TGT_NS   = 2'd2
  } bp_tgt_e;
endpackage

// File: rtl/bp_route.sv
module bp_route
  import bp_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int IDX_W   = 4,
  parameter int OFF_W   = 12
) (
  input  logic             cfg_sec_ext_i,
  input  logic             cfg_groups_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic             secure_i,
  output logic             in_range_o,
  output bp_tgt_e          tgt_o
);
  logic ns_view;
  logic hit_bp;
  logic hit_alias;

  assign in_range_o = ({1'b0, cpu_idx_i} < (IDX_W+1)'(NUM_CPU));
  // banked view: only when security extensions exist and access is non-secure
  assign ns_view    = cfg_sec_ext_i & ~secure_i;
  assign hit_bp     = (offset_i == OFF_W'(BP_OFF));
  assign hit_alias  = (offset_i == OFF_W'(ALIAS_OFF));

  always_comb begin
    tgt_o = TGT_NONE;
    if (in_range_o) begin
      if (hit_bp) begin
        tgt_o = ns_view ? TGT_NS : TGT_PRI;
      end else if (hit_alias && cfg_groups_i && !ns_view) begin
        tgt_o = TGT_NS;
      end
    end
  end
endmodule

// File: rtl/bp_cell.sv
module bp_cell
  import bp_pkg::*;
#(
  parameter int MIN_VAL = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [BP_W-1:0] wval_i,
  output logic [BP_W-1:0] q_o
);
  localparam logic [BP_W-1:0] MinV = BP_W'(MIN_VAL);

  logic [BP_W-1:0] clamped;

  assign clamped = (wval_i < MinV) ? MinV : wval_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= MinV;
    end else if (we_i) begin
      q_o <= clamped;
    end
  end
endmodule

// File: rtl/bp_bank_regs.sv
module bp_bank_regs
  import bp_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int IDX_W   = 4,
  parameter int OFF_W   = 12,
  parameter int DATA_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_sec_ext_i,
  input  logic                    cfg_groups_i,
  input  logic [IDX_W-1:0]        cpu_idx_i,
  input  logic [OFF_W-1:0]        offset_i,
  input  logic                    secure_i,
  input  logic                    wr_en_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [NUM_CPU*BP_W-1:0] bp_sec_o,
  output logic [NUM_CPU*BP_W-1:0] bp_ns_o
);
  localparam int SEL_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic            in_range;
  bp_tgt_e         tgt;
  logic [BP_W-1:0] wval;
  logic [SEL_W-1:0] sel;
  logic [BP_W-1:0] sec_q [NUM_CPU];
  logic [BP_W-1:0] ns_q  [NUM_CPU];
  logic [BP_W-1:0] rd_val;

  assign wval = wdata_i[BP_W-1:0];
  assign sel  = cpu_idx_i[SEL_W-1:0];

  bp_route #(
    .NUM_CPU (NUM_CPU),
    .IDX_W   (IDX_W),
    .OFF_W   (OFF_W)
  ) u_route (
    .cfg_sec_ext_i (cfg_sec_ext_i),
    .cfg_groups_i  (cfg_groups_i),
    .cpu_idx_i     (cpu_idx_i),
    .offset_i      (offset_i),
    .secure_i      (secure_i),
    .in_range_o    (in_range),
    .tgt_o         (tgt)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic hit;
    assign hit = wr_en_i && (cpu_idx_i == IDX_W'(c));

    bp_cell #(.MIN_VAL(PRI_MIN)) u_pri (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (hit && (tgt == TGT_PRI)),
      .wval_i (wval),
      .q_o    (sec_q[c])
    );

    bp_cell #(.MIN_VAL(NS_MIN)) u_ns (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (hit && (tgt == TGT_NS)),
      .wval_i (wval),
      .q_o    (ns_q[c])
    );

    assign bp_sec_o[c*BP_W +: BP_W] = sec_q[c];
    assign bp_ns_o[c*BP_W +: BP_W]  = ns_q[c];
  end

  always_comb begin
    unique case (tgt)
      TGT_PRI: rd_val = sec_q[sel];
      TGT_NS:  rd_val = ns_q[sel];
      default: rd_val = '0;
    endcase
  end

  assign rdata_o = DATA_W'(rd_val);
endmodule

// File: rtl/bp_bank_chk.sv
module bp_bank_chk
  import bp_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int IDX_W   = 4,
  parameter int OFF_W   = 12,
  parameter int DATA_W  = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cfg_sec_ext_i,
  input logic                    cfg_groups_i,
  input logic [IDX_W-1:0]        cpu_idx_i,
  input logic [OFF_W-1:0]        offset_i,
  input logic                    secure_i,
  input logic                    wr_en_i,
  input logic [DATA_W-1:0]       wdata_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic [NUM_CPU*BP_W-1:0] bp_sec_o,
  input logic [NUM_CPU*BP_W-1:0] bp_ns_o
);
  localparam int SEL_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic            in_rng, at_bp, at_alias, nsv;
  logic [SEL_W-1:0] sidx;
  logic [BP_W-1:0] sec_arr [NUM_CPU];
  logic [BP_W-1:0] ns_arr  [NUM_CPU];
  logic [BP_W-1:0] sec_at, ns_at;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_unpack
    assign sec_arr[c] = bp_sec_o[c*BP_W +: BP_W];
    assign ns_arr[c]  = bp_ns_o[c*BP_W +: BP_W];
  end

  assign in_rng   = ({1'b0, cpu_idx_i} < (IDX_W+1)'(NUM_CPU));
  assign at_bp    = (offset_i == OFF_W'(BP_OFF));
  assign at_alias = (offset_i == OFF_W'(ALIAS_OFF));
  assign nsv      = cfg_sec_ext_i && !secure_i;
  assign sidx     = cpu_idx_i[SEL_W-1:0];
  assign sec_at   = sec_arr[sidx];
  assign ns_at    = ns_arr[sidx];

  // R2
  rdata_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:BP_W] == '0);

  // R3
  ns_bank_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rng && at_bp && nsv) |-> (rdata_o[BP_W-1:0] == ns_at));

  // R4
  pri_bank_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rng && at_bp && !nsv) |-> (rdata_o[BP_W-1:0] == sec_at));

  // R5
  alias_nogrp_wi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && at_alias && !cfg_groups_i) |=> ($stable(bp_ns_o) && $stable(bp_sec_o)));

  // R5
  alias_nogrp_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_alias && !cfg_groups_i) |-> (rdata_o == '0));

  // R6
  alias_ns_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_alias && nsv) |-> (rdata_o == '0));

  // R6
  alias_ns_wi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && at_alias && nsv) |=> ($stable(bp_ns_o) && $stable(bp_sec_o)));

  // R7
  alias_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rng && at_alias && cfg_groups_i && !nsv) |-> (rdata_o[BP_W-1:0] == ns_at));

  // R8
  ns_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rng |-> (ns_at != '0));

  // R9
  unmapped_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_bp && !at_alias) |-> (rdata_o == '0));

  // R10
  oor_wi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !in_rng) |=> ($stable(bp_sec_o) && $stable(bp_ns_o)));

  // R11
  pri_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_rng && at_bp && !nsv) |=> (sec_arr[$past(sidx)] == $past(wdata_i[BP_W-1:0])));
endmodule

bind bp_bank_regs bp_bank_chk #(
  .NUM_CPU (NUM_CPU),
  .IDX_W   (IDX_W),
  .OFF_W   (OFF_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_sec_ext_i (cfg_sec_ext_i),
  .cfg_groups_i  (cfg_groups_i),
  .cpu_idx_i     (cpu_idx_i),
  .offset_i      (offset_i),
  .secure_i      (secure_i),
  .wr_en_i       (wr_en_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .bp_sec_o      (bp_sec_o),
  .bp_ns_o       (bp_ns_o)
);

// File: tb/bp_bank_regs_tb.sv
module bp_bank_regs_tb;
  localparam int CLK_P  = 10;
  localparam int NCPU   = 8;
  localparam int IDX_W  = 4;
  localparam int OFF_W  = 12;
  localparam int DW     = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sec_ext = 1'b0;
  logic              groups = 1'b0;
  logic [IDX_W-1:0]  cpu_idx = '0;
  logic [OFF_W-1:0]  offset = '0;
  logic              secure = 1'b0;
  logic              wr_en = 1'b0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic [NCPU*3-1:0] bp_sec, bp_ns;

  int vectors = 0;
  int misses  = 0;
  int pri_m [NCPU];
  int ns_m  [NCPU];
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bp_bank_regs #(.NUM_CPU(NCPU), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_sec_ext_i(sec_ext), .cfg_groups_i(groups),
    .cpu_idx_i(cpu_idx), .offset_i(offset), .secure_i(secure), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .bp_sec_o(bp_sec), .bp_ns_o(bp_ns)
  );

  // 0: none, 1: primary, 2: non-secure
  function automatic int target(int cpu, int off, bit sec);
    if (cpu >= NCPU) return 0;
    if (off == 'h08) return (sec_ext && !sec) ? 2 : 1;
    if (off == 'h1c) return (!groups || (sec_ext && !sec)) ? 0 : 2;
    return 0;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag, int cpu, int off, bit sec);
    logic [NCPU*3-1:0] es, en;
    int t;
    logic [DW-1:0] er;
    for (int c = 0; c < NCPU; c++) begin
      es[c*3 +: 3] = 3'(pri_m[c]);
      en[c*3 +: 3] = 3'(ns_m[c]);
    end
    t  = target(cpu, off, sec);
    er = (t == 1) ? DW'(pri_m[cpu]) : (t == 2) ? DW'(ns_m[cpu]) : '0;
    check(tag, rdata, er);
    check(tag, DW'(bp_sec), DW'(es));
    check(tag, DW'(bp_ns), DW'(en));
  endtask

  task automatic apply(string tag, int cpu, int off, bit sec, bit we, logic [DW-1:0] wd);
    int t, v;
    @(negedge clk);
    cpu_idx = IDX_W'(cpu); offset = OFF_W'(off); secure = sec; wr_en = we; wdata = wd;
    #1;
    compare(tag, cpu, off, sec);
    t = target(cpu, off, sec);
    v = int'(wd[2:0]);
    @(posedge clk);
    if (we && t == 1) pri_m[cpu] = v;
    if (we && t == 2) ns_m[cpu] = (v < 1) ? 1 : v;
  endtask

  task automatic set_cfg(bit se, bit gr);
    @(negedge clk);
    sec_ext = se; groups = gr; wr_en = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < NCPU; c++) begin pri_m[c] = 0; ns_m[c] = 1; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    apply("R1", 0, 'h08, 1'b1, 1'b0, '0);
    apply("R1", 7, 'h1c, 1'b1, 1'b0, '0);
    set_cfg(1'b1, 1'b1);
    apply("R1", 3, 'h08, 1'b0, 1'b0, '0);
    // R2 only low bits, R4 secure primary
    apply("R2", 2, 'h08, 1'b1, 1'b1, 32'hFFFF_FFFD);
    apply("R4", 2, 'h08, 1'b1, 1'b0, '0);
    // R3 non-secure bank
    apply("R3", 2, 'h08, 1'b0, 1'b1, 32'h0000_0013);
    apply("R3", 2, 'h08, 1'b0, 1'b0, '0);
    apply("R4", 2, 'h08, 1'b1, 1'b0, '0);
    // R8 clamp
    apply("R8", 2, 'h08, 1'b0, 1'b1, 32'h0000_0008);
    apply("R8", 2, 'h08, 1'b0, 1'b0, '0);
    apply("R8", 2, 'h08, 1'b1, 1'b1, 32'h0);
    apply("R8", 2, 'h08, 1'b1, 1'b0, '0);
    // R7 secure view of alias
    apply("R7", 2, 'h1c, 1'b1, 1'b1, 32'h6);
    apply("R7", 2, 'h08, 1'b0, 1'b0, '0);
    apply("R8", 2, 'h1c, 1'b1, 1'b1, 32'h0);
    apply("R8", 2, 'h1c, 1'b1, 1'b0, '0);
    // R6 non-secure alias RAZ/WI
    apply("R6", 2, 'h1c, 1'b0, 1'b1, 32'h5);
    apply("R6", 2, 'h08, 1'b0, 1'b0, '0);
    // R5 no grouping
    set_cfg(1'b1, 1'b0);
    apply("R5", 4, 'h1c, 1'b1, 1'b1, 32'h7);
    apply("R5", 4, 'h1c, 1'b1, 1'b0, '0);
    apply("R5", 4, 'h08, 1'b0, 1'b0, '0);
    set_cfg(1'b0, 1'b0);
    apply("R5", 4, 'h1c, 1'b0, 1'b1, 32'h3);
    // R4 without security extensions, any attribute
    apply("R4", 5, 'h08, 1'b0, 1'b1, 32'h4);
    apply("R4", 5, 'h08, 1'b1, 1'b0, '0);
    set_cfg(1'b0, 1'b1);
    // R7 grouping without security: non-secure access sees alias
    apply("R7", 5, 'h1c, 1'b0, 1'b1, 32'h2);
    apply("R7", 5, 'h1c, 1'b1, 1'b0, '0);
    // R9 unmapped offsets
    apply("R9", 1, 'h04, 1'b1, 1'b1, 32'h7);
    apply("R9", 1, 'h0c, 1'b0, 1'b1, 32'h7);
    apply("R9", 1, 'h09, 1'b1, 1'b0, '0);
    apply("R9", 1, 'h11c, 1'b1, 1'b1, 32'h6);
    // R10 out-of-range processor
    apply("R10", 8, 'h08, 1'b1, 1'b1, 32'h7);
    apply("R10", 15, 'h1c, 1'b1, 1'b1, 32'h7);
    apply("R10", 9, 'h08, 1'b1, 1'b0, '0);
    // R11 isolation and write timing, every processor
    set_cfg(1'b1, 1'b1);
    for (int c = 0; c < NCPU; c++) begin
      apply("R11", c, 'h08, 1'b1, 1'b1, 32'((c + 3) % 8));
      apply("R11", c, 'h08, 1'b0, 1'b1, 32'((c * 5) % 8));
    end
    for (int c = 0; c < NCPU; c++) begin
      apply("R11", c, 'h08, 1'b1, 1'b0, '0);
      apply("R11", c, 'h1c, 1'b1, 1'b0, '0);
    end
    // R11 back-to-back writes, read shows old value before the edge
    apply("R11", 6, 'h08, 1'b1, 1'b1, 32'h1);
    apply("R11", 6, 'h08, 1'b1, 1'b1, 32'h7);
    apply("R11", 6, 'h08, 1'b1, 1'b0, '0);
    // R1 reset again mid-run
    @(negedge clk);
    rst_ni = 1'b0; wr_en = 1'b0;
    for (int c = 0; c < NCPU; c++) begin pri_m[c] = 0; ns_m[c] = 1; end
    @(negedge clk);
    rst_ni = 1'b1;
    apply("R1", 6, 'h08, 1'b1, 1'b0, '0);
    apply("R1", 6, 'h1c, 1'b1, 1'b0, '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule